// File: doc/BRIEF.md
# Presettable Saturating Line-Error Counter Bank

This block keeps three 8-bit event tallies for a 2.048 Mb/s framed receiver. The first counts bipolar code violations. The second counts CRC-4 code word errors. The third counts errored frame alignment words. The error detectors sit upstream and deliver one single-cycle strobe per event. Control inputs from the receiver qualify each strobe: a resync-in-progress flag, a CRC-4 enable, a zero-substitution decode mode bit, and a flag that marks a violation as part of a received substitution code word.

A host writes a counter to set a threshold. The counter then climbs from that value and sticks at 255. From that point every further qualifying error raises a one-cycle interrupt pulse, if the interrupt mask input allows it. This continues until the host writes a value other than 255. Reads are combinational, select one counter by index, and leave the count unchanged.

No data stream passes through the block. The host port and the alarm pins are plain control signals, so no valid/ready handshake or back-pressure applies. A write completes in the cycle it is presented.

Top module: `line_err_counter_bank`

## Requirements
- R1: After reset all three counters read 0 and `irq_pulse` is low.
- R2: A qualifying error strobe raises its counter by exactly one, and the new value is readable one clock later.
- R3: A counter that holds 255 stays at 255 on further errors and never wraps to 0.
- R4: When a counter holds 255, a qualifying error on it produces `irq_pulse` high for the one following cycle, provided `irq_mask_en` is 1. No pulse occurs when the mask is 0 or when the counter is below 255, including the error that first brings it to 255.
- R5: A host write with `host_sel` 0 (violations), 1 (CRC-4) or 2 (frame) loads `host_wdata` into that counter. Counting then continues upward from the loaded value.
- R6: The violation counter counts whether or not resync is in progress. A violation is dropped only when `zsub_mode` and `zsub_word` are both 1.
- R7: While `resync_busy` is 1, CRC-4 errors and frame errors are not counted.
- R8: CRC-4 errors are counted only while `crc4_en` is 1.
- R9: A host write to a counter and an error on that same counter in the same cycle: the written value is stored, and the error is dropped without an interrupt.
- R10: Reading does not alter a count. `host_rsel` of 3 reads 0, and a write with `host_sel` of 3 changes no counter.
- R11: Post-saturation errors on several counters in the same cycle yield a single one-cycle `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bpv_stb | input | 1 | One bipolar violation detected |
| crc_err_stb | input | 1 | One CRC-4 code word error detected |
| fas_err_stb | input | 1 | One frame alignment word error detected |
| resync_busy | input | 1 | Receiver is resynchronising |
| crc4_en | input | 1 | CRC-4 checking enabled |
| zsub_mode | input | 1 | Zero-substitution decode mode selected |
| zsub_word | input | 1 | Current violation belongs to a substitution code word |
| irq_mask_en | input | 1 | Allows saturation interrupts |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 violations, 1 CRC-4, 2 frame, 3 none |
| host_wdata | input | 8 | Preset value |
| host_rsel | input | 2 | Read select, same coding as `host_sel` |
| host_rdata | output | 8 | Selected count (0 for select 3) |
| irq_pulse | output | 1 | One-cycle interrupt on a post-saturation error |

## Verification
Two functions of this block can fall in the same cycle: a host preset and an error strobe aimed at the same counter. The bench drives a write and the matching strobe at the same negative edge. After the next rising edge it reads back the written value with no increment, and it checks that no interrupt followed even when the counter was full. A second overlap occurs when several saturated counters take errors together. The bench checks that these merge into one pulse, which is high for exactly one cycle.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  localparam int NUM_CNT = 3;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_BPV  = 2'd0,
    SRC_CRC  = 2'd1,
    SRC_FAS  = 2'd2,
    SRC_NONE = 2'd3
  } err_src_e;
endpackage

// File: rtl/err_event_gate.sv
module err_event_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bpv_stb,
  input  logic       crc_err_stb,
  input  logic       fas_err_stb,
  input  logic       resync_busy,
  input  logic       crc4_en,
  input  logic       zsub_mode,
  input  logic       zsub_word,
  output logic [2:0] ev_o
);
  import err_cnt_pkg::*;

  logic zsub_drop;
  assign zsub_drop = zsub_mode & zsub_word;

  always_comb begin
    ev_o          = '0;
    ev_o[SRC_BPV] = bpv_stb & ~zsub_drop;
    ev_o[SRC_CRC] = crc_err_stb & crc4_en & ~resync_busy;
    ev_o[SRC_FAS] = fas_err_stb & ~resync_busy;
  end

  p_zsub_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zsub_mode && zsub_word) |-> !ev_o[SRC_BPV]);
  p_bpv_any_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_stb && !zsub_mode) |-> ev_o[SRC_BPV]);
  p_resync_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_busy |-> (!ev_o[SRC_CRC] && !ev_o[SRC_FAS]));
  p_crc_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !crc4_en |-> !ev_o[SRC_CRC]);
endmodule

// File: rtl/sat_err_counter.sv
module sat_err_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic         over_o
);
  localparam logic [W-1:0] FULL = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    q <= '0;
    else if (wr_i)                 q <= wdata_i;
    else if (inc_i && q != FULL)   q <= q + ONE;
  end

  assign count_o = q;
  assign over_o  = inc_i & ~wr_i & (q == FULL);

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q == FULL && !wr_i) |=> (q == FULL));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i && q != FULL) |=> (q == $past(q) + ONE));
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q == $past(wdata_i)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(q));
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int N     = 3,
  parameter int W     = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [SEL_W-1:0] host_sel,
  input  logic [SEL_W-1:0] host_rsel,
  input  logic [N*W-1:0]   cnt_flat,
  output logic [N-1:0]     wr_vec,
  output logic [W-1:0]     rdata
);
  always_comb begin
    wr_vec = '0;
    rdata  = '0;
    for (int i = 0; i < N; i++) begin
      if (host_wr && host_sel == SEL_W'(i)) wr_vec[i] = 1'b1;
      if (host_rsel == SEL_W'(i)) rdata = cnt_flat[i*W +: W];
    end
  end

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  p_no_stray_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |-> (wr_vec == '0));
endmodule

// File: rtl/line_err_counter_bank.sv
module line_err_counter_bank #(
  parameter int CNT_W = err_cnt_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bpv_stb,
  input  logic             crc_err_stb,
  input  logic             fas_err_stb,
  input  logic             resync_busy,
  input  logic             crc4_en,
  input  logic             zsub_mode,
  input  logic             zsub_word,
  input  logic             irq_mask_en,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [CNT_W-1:0] host_wdata,
  input  logic [1:0]       host_rsel,
  output logic [CNT_W-1:0] host_rdata,
  output logic             irq_pulse
);
  import err_cnt_pkg::*;
  localparam int N = NUM_CNT;

  logic [N-1:0]       ev;
  logic [N-1:0]       wr_vec;
  logic [N-1:0]       over;
  logic [N*CNT_W-1:0] cnt_flat;
  logic               irq_q;

  err_event_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .bpv_stb(bpv_stb), .crc_err_stb(crc_err_stb), .fas_err_stb(fas_err_stb),
    .resync_busy(resync_busy), .crc4_en(crc4_en),
    .zsub_mode(zsub_mode), .zsub_word(zsub_word),
    .ev_o(ev)
  );

  host_reg_port #(.N(N), .W(CNT_W), .SEL_W(SEL_W)) u_host (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_sel(host_sel), .host_rsel(host_rsel),
    .cnt_flat(cnt_flat), .wr_vec(wr_vec), .rdata(host_rdata)
  );

  for (genvar g = 0; g < N; g++) begin : g_cnt
    sat_err_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc_i(ev[g]), .wr_i(wr_vec[g]), .wdata_i(host_wdata),
      .count_o(cnt_flat[g*CNT_W +: CNT_W]), .over_o(over[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_mask_en & (|over);
  end

  assign irq_pulse = irq_q;

  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask_en |=> !irq_pulse);
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(|over));
  p_irq_merge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_en && (|over)) |=> irq_pulse);
endmodule

// File: tb/test_line_err_counter_bank.sv
module test_line_err_counter_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bpv_stb = 0, crc_err_stb = 0, fas_err_stb = 0;
  logic resync_busy = 0, crc4_en = 0, zsub_mode = 0, zsub_word = 0;
  logic irq_mask_en = 0, host_wr = 0;
  logic [1:0] host_sel = 0, host_rsel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic irq_pulse;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_err_counter_bank i_line_err_counter_bank (
    .clk(clk), .rst_n(rst_n),
    .bpv_stb(bpv_stb), .crc_err_stb(crc_err_stb), .fas_err_stb(fas_err_stb),
    .resync_busy(resync_busy), .crc4_en(crc4_en),
    .zsub_mode(zsub_mode), .zsub_word(zsub_word),
    .irq_mask_en(irq_mask_en), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rsel(host_rsel),
    .host_rdata(host_rdata), .irq_pulse(irq_pulse)
  );

  // stim {bpv,crc,fas,resync,crc4_en,zmode,zword}, then expected bpv/crc/fas
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {7'b1110100, 8'd1, 8'd1, 8'd1},
    {7'b1111100, 8'd2, 8'd1, 8'd1},
    {7'b1100000, 8'd3, 8'd1, 8'd1},
    {7'b1000111, 8'd3, 8'd1, 8'd1},
    {7'b1000110, 8'd4, 8'd1, 8'd1},
    {7'b1000101, 8'd5, 8'd1, 8'd1},
    {7'b0110100, 8'd5, 8'd2, 8'd2},
    {7'b0011100, 8'd5, 8'd2, 8'd2},
    {7'b0101100, 8'd5, 8'd2, 8'd2},
    {7'b0000100, 8'd5, 8'd2, 8'd2},
    {7'b0110111, 8'd5, 8'd3, 8'd3},
    {7'b1110100, 8'd6, 8'd4, 8'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    host_rsel = s;
    #1;
    v = host_rdata;
  endtask

  task automatic chk_cnt(input string req, input logic [1:0] s, input int exp);
    logic [7:0] v;
    rd(s, v);
    chk(req, int'(v), exp);
  endtask

  // one cycle: optional write plus strobes; results sampled after the edge
  task automatic cycle(input logic b, input logic c, input logic f,
                       input logic w, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bpv_stb = b; crc_err_stb = c; fas_err_stb = f;
    host_wr = w; host_sel = s; host_wdata = d;
    @(posedge clk);
    #1;
    bpv_stb = 0; crc_err_stb = 0; fas_err_stb = 0; host_wr = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nfail++; nvec++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_cnt("R1 bpv reset", 2'd0, 0);
    chk_cnt("R1 crc reset", 2'd1, 0);
    chk_cnt("R1 fas reset", 2'd2, 0);
    chk("R1 irq reset", int'(irq_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R2 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {bpv_stb, crc_err_stb, fas_err_stb, resync_busy, crc4_en, zsub_mode, zsub_word} = VEC[i][30:24];
      @(posedge clk);
      #1;
      bpv_stb = 0; crc_err_stb = 0; fas_err_stb = 0;
      chk_cnt("R2/R6 bpv table", 2'd0, int'(VEC[i][23:16]));
      chk_cnt("R7/R8 crc table", 2'd1, int'(VEC[i][15:8]));
      chk_cnt("R7 fas table", 2'd2, int'(VEC[i][7:0]));
      chk("R4 no irq below full", int'(irq_pulse), 0);
    end
    resync_busy = 0; crc4_en = 1; zsub_mode = 0; zsub_word = 0;
    irq_mask_en = 1;

    // R5 preset and climb, R3 saturation, R4 interrupts
    cycle(0, 0, 0, 1, 2'd0, 8'hFD);
    chk_cnt("R5 preset", 2'd0, 253);
    cycle(1, 0, 0, 0, 2'd0, 8'h00);
    chk_cnt("R5 count from preset", 2'd0, 254);
    cycle(1, 0, 0, 0, 2'd0, 8'h00);
    chk_cnt("R3 reach full", 2'd0, 255);
    chk("R4 no irq on reaching full", int'(irq_pulse), 0);
    cycle(1, 0, 0, 0, 2'd0, 8'h00);
    chk_cnt("R3 no wrap", 2'd0, 255);
    chk("R4 irq after full", int'(irq_pulse), 1);
    cycle(1, 0, 0, 0, 2'd0, 8'h00);
    chk("R4 irq again", int'(irq_pulse), 1);
    cycle(0, 0, 0, 0, 2'd0, 8'h00);
    chk("R4 irq one cycle", int'(irq_pulse), 0);
    irq_mask_en = 0;
    cycle(1, 0, 0, 0, 2'd0, 8'h00);
    chk("R4 masked", int'(irq_pulse), 0);
    chk_cnt("R3 masked still full", 2'd0, 255);
    irq_mask_en = 1;

    // R9 write/event collision
    cycle(0, 1, 0, 1, 2'd1, 8'hFF);
    chk_cnt("R9 write wins crc", 2'd1, 255);
    chk("R9 no irq on collision", int'(irq_pulse), 0);
    cycle(0, 1, 0, 1, 2'd1, 8'hFF);
    chk("R9 full collision no irq", int'(irq_pulse), 0);
    cycle(0, 0, 1, 1, 2'd2, 8'h10);
    chk_cnt("R9 write wins fas", 2'd2, 16);

    // R10 select 3 and non-destructive read
    cycle(0, 0, 0, 1, 2'd3, 8'h55);
    chk_cnt("R10 bad sel bpv", 2'd0, 255);
    chk_cnt("R10 bad sel crc", 2'd1, 255);
    chk_cnt("R10 bad sel fas", 2'd2, 16);
    chk_cnt("R10 read sel3", 2'd3, 0);
    host_rsel = 2'd2;
    @(posedge clk); @(posedge clk); #1;
    chk_cnt("R10 reread", 2'd2, 16);

    // R11 merged interrupt
    cycle(1, 1, 0, 0, 2'd0, 8'h00);
    chk("R11 merged irq", int'(irq_pulse), 1);
    cycle(0, 0, 0, 0, 2'd0, 8'h00);
    chk("R11 single pulse", int'(irq_pulse), 0);

    // rewrite below full ends interrupts (R4)
    cycle(0, 0, 0, 1, 2'd0, 8'h80);
    cycle(1, 0, 0, 0, 2'd0, 8'h00);
    chk_cnt("R5 rewrite count", 2'd0, 129);
    chk("R4 irq stops after rewrite", int'(irq_pulse), 0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk_cnt("R1 reset clears crc", 2'd1, 0);
    chk("R1 reset irq", int'(irq_pulse), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule